// File: doc/BRIEF.md
# Double-Clocked Pseudo-Dual-Port Memory

This block gives the rest of a chip a memory with a separate read port and write port on one system clock. Inside, it has only one single-port storage array with one shared address and data path. A second clock runs at twice the system rate, and its rising edges line up with the system clock's rising edges. The array is used twice in every system cycle. The fast edge in the middle of the cycle serves the read. The fast edge that coincides with the next system edge serves the write.

In any system cycle the caller may do nothing, read, write, or read and write. Read data appears on the output before the end of the cycle in which the read was issued. The output register then holds that word until the next read. Because the read phase always comes first, a read and a write to the same address in one cycle return the old contents. The new word can be read from the next cycle on.

Reset is synchronous and active low. The caller must release it just after a rising system clock edge, before the middle fast edge of that cycle. The phase logic then starts in step with the system clock.

Top module: `pdp_ram`

## Requirements
- R1: While `rst_n` is low, and after its release until the first read completes, `rd_data` is all zeros. Array contents are not cleared by reset.
- R2: When `rd_en` is 1 in a system cycle, `rd_data` takes the word stored at `rd_addr`. It changes on the fast edge in the middle of that cycle, so the word is valid before the next rising system edge.
- R3: In a cycle with `rd_en` 0, `rd_data` keeps the last word read and does not change.
- R4: When `wr_en` is 1, the word on `wr_data` is stored at `wr_addr`. Both must be presented in the same cycle as `wr_en`. The word is stored on the fast edge that ends the cycle, and a read in any later cycle returns it.
- R5: A read and a write to different addresses in the same cycle both take effect.
- R6: When a read and a write in the same cycle use the same address, `rd_data` returns the word stored before the write. A read in the next cycle returns the new word.
- R7: Writes in consecutive cycles are each stored. When they target one address, the last write wins.
- R8: An internal phase alternates on every fast edge: read phase on the mid-cycle edge, write phase on the edge that coincides with the system edge. `rd_data` never changes on a write-phase edge.
- R9: The array has one access path. In the read phase its address comes from `rd_addr` and it is never written. A write to the array happens only in the write phase of a cycle with `wr_en` set.
- R10: In a cycle with `wr_en` 0, the values on `wr_addr` and `wr_data` are ignored, and the stored contents stay as they were.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| clk_fast | input | 1 | Twice-rate clock, rising edges aligned with `clk` |
| rst_n | input | 1 | Synchronous active-low reset, released just after a `clk` rising edge |
| rd_en | input | 1 | Read request for this cycle |
| rd_addr | input | AW = clog2(DEPTH) | Read address |
| rd_data | output | DW | Read data, held between reads |
| wr_en | input | 1 | Write request for this cycle |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |

## Verification
The read and the write to the same address can land in one system cycle. This is where time-sharing the array could go wrong. The bench provokes it by issuing both requests to one address with a different data word. This is done at low, middle and top addresses, and again right after a mid-run reset, to show that the phase has realigned. The result is judged against a two-port reference model that applies the read before the write: the read must return the old word, and the following cycle must return the new one. Separate samples taken before and after the mid-cycle fast edge show that the read phase really comes first.

// File: rtl/pdp_ram_pkg.sv
package pdp_ram_pkg;

    // Which access the single array path serves on a fast edge
    typedef enum logic {
        PH_READ  = 1'b0,
        PH_WRITE = 1'b1
    } phase_e;

endpackage

// File: rtl/pdp_phase_gen.sv
module pdp_phase_gen
    import pdp_ram_pkg::*;
(
    input  logic   clk,
    input  logic   clk_fast,
    input  logic   rst_n,
    output phase_e phase
);

    // System-side toggle flips on every system edge; the fast side copies it.
    // They differ only on the first fast edge after a system edge (mid-cycle).
    logic tgl_d, tgl_q;
    logic seen_d, seen_q;

    always_comb begin
        tgl_d  = ~tgl_q;
        seen_d = tgl_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tgl_q <= 1'b1;
        else        tgl_q <= tgl_d;
    end

    always_ff @(posedge clk_fast) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= seen_d;
    end

    assign phase = (tgl_q == seen_q) ? PH_WRITE : PH_READ;

endmodule

// File: rtl/pdp_port_mux.sv
module pdp_port_mux
    import pdp_ram_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  phase_e          phase,
    input  logic            rd_en,
    input  logic [AW-1:0]   rd_addr,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [DW-1:0]   wr_data,
    output logic            acc_en,
    output logic            acc_wr,
    output logic [AW-1:0]   acc_addr,
    output logic [DW-1:0]   acc_wdata
);

    always_comb begin
        acc_wdata = wr_data;
        if (phase == PH_READ) begin
            acc_en   = rd_en;
            acc_wr   = 1'b0;
            acc_addr = rd_addr;
        end else begin
            acc_en   = wr_en;
            acc_wr   = 1'b1;
            acc_addr = wr_addr;
        end
    end

endmodule

// File: rtl/pdp_sp_array.sv
module pdp_sp_array #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    parameter int AW    = 4
) (
    input  logic            clk_fast,
    input  logic            rst_n,
    input  logic            acc_en,
    input  logic            acc_wr,
    input  logic [AW-1:0]   acc_addr,
    input  logic [DW-1:0]   acc_wdata,
    output logic [DW-1:0]   acc_rdata
);

    localparam logic [AW:0] LIMIT = (AW+1)'(DEPTH);

    logic [DW-1:0] mem_q [DEPTH];
    logic          in_range;

    assign in_range = ({1'b0, acc_addr} < LIMIT);

    always_ff @(posedge clk_fast) begin
        if (rst_n && acc_en && acc_wr && in_range)
            mem_q[acc_addr] <= acc_wdata;
    end

    always_comb begin
        acc_rdata = in_range ? mem_q[acc_addr] : '0;
    end

endmodule

// File: rtl/pdp_ram.sv
module pdp_ram
    import pdp_ram_pkg::*;
#(
    parameter  int DEPTH = 16,
    parameter  int DW    = 8,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic            clk,
    input  logic            clk_fast,
    input  logic            rst_n,
    input  logic            rd_en,
    input  logic [AW-1:0]   rd_addr,
    output logic [DW-1:0]   rd_data,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [DW-1:0]   wr_data
);

    typedef struct packed {
        logic [DW-1:0] rd;
    } state_t;

    phase_e        phase;
    logic          acc_en;
    logic          acc_wr;
    logic [AW-1:0] acc_addr;
    logic [DW-1:0] acc_wdata;
    logic [DW-1:0] acc_rdata;
    state_t        st_d, st_q;

    pdp_phase_gen u_phase (
        .clk      (clk),
        .clk_fast (clk_fast),
        .rst_n    (rst_n),
        .phase    (phase)
    );

    pdp_port_mux #(.AW(AW), .DW(DW)) u_mux (
        .phase     (phase),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .acc_en    (acc_en),
        .acc_wr    (acc_wr),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata)
    );

    pdp_sp_array #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_array (
        .clk_fast  (clk_fast),
        .rst_n     (rst_n),
        .acc_en    (acc_en),
        .acc_wr    (acc_wr),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata),
        .acc_rdata (acc_rdata)
    );

    // Output holding register: loads only on a read-phase access
    always_comb begin
        st_d = st_q;
        if (acc_en && !acc_wr)
            st_d.rd = acc_rdata;
    end

    always_ff @(posedge clk_fast) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.rd;

endmodule

// File: rtl/pdp_ram_chk.sv
module pdp_ram_chk
    import pdp_ram_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input logic            clk_fast,
    input logic            rst_n,
    input logic            rd_en,
    input logic [AW-1:0]   rd_addr,
    input logic            wr_en,
    input logic [DW-1:0]   rd_data,
    input phase_e          phase,
    input logic            acc_en,
    input logic            acc_wr,
    input logic [AW-1:0]   acc_addr
);

    AST_PHASE_TO_WRITE: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (phase == PH_READ) |=> (phase == PH_WRITE));                       // R8

    AST_PHASE_TO_READ: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (phase == PH_WRITE) |=> (phase == PH_READ));                       // R8

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (phase == PH_READ && !rd_en) |=> $stable(rd_data));                // R3

    AST_HOLD_IN_WRITE_PHASE: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (phase == PH_WRITE) |=> $stable(rd_data));                         // R8

    AST_WRITE_GATED: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (acc_en && acc_wr) |-> (phase == PH_WRITE && wr_en));              // R9

    AST_READ_PATH: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (phase == PH_READ && rd_en) |-> (acc_en && !acc_wr && acc_addr == rd_addr)); // R9

endmodule

bind pdp_ram pdp_ram_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk_fast (clk_fast),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .wr_en    (wr_en),
    .rd_data  (rd_data),
    .phase    (phase),
    .acc_en   (acc_en),
    .acc_wr   (acc_wr),
    .acc_addr (acc_addr)
);

// File: tb/sim_pdp_ram.sv
`timescale 1ns/100ps
module sim_pdp_ram;

    localparam int DEPTH = 16;
    localparam int DW    = 8;
    localparam int AW    = 4;
    localparam int NV    = 17;

    logic          clk = 1'b0;
    logic          clk_fast = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [DW-1:0] ref_mem [DEPTH];
    logic [DW-1:0] ref_rd = '0;

    // 500 MHz fast clock; the 250 MHz system clock is divided from it
    always #1 clk_fast = ~clk_fast;
    always @(posedge clk_fast) clk <= ~clk;

    pdp_ram #(.DEPTH(DEPTH), .DW(DW)) u0 (
        .clk      (clk),
        .clk_fast (clk_fast),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    // {req, rd_en, rd_addr, wr_en, wr_addr, wr_data}
    localparam logic [21:0] VEC [NV] = '{
        {4'd4,  1'b0, 4'h0, 1'b1, 4'h3, 8'hA5},  // R4 write, output still reset value
        {4'd7,  1'b0, 4'h0, 1'b1, 4'h7, 8'h3C},  // R7 back-to-back write
        {4'd4,  1'b1, 4'h3, 1'b0, 4'h0, 8'h00},  // R4 visible next cycle
        {4'd6,  1'b1, 4'h3, 1'b1, 4'h3, 8'h5A},  // R6 collision -> old word
        {4'd6,  1'b1, 4'h3, 1'b0, 4'h0, 8'h00},  // R6 new word next cycle
        {4'd10, 1'b0, 4'h0, 1'b0, 4'h3, 8'hFF},  // R10 / R3 idle with junk write data
        {4'd10, 1'b1, 4'h3, 1'b0, 4'h0, 8'h00},  // R10 contents unchanged
        {4'd7,  1'b0, 4'h0, 1'b1, 4'h9, 8'h11},  // R7 first of two writes
        {4'd7,  1'b0, 4'h0, 1'b1, 4'h9, 8'h22},  // R7 second write same address
        {4'd5,  1'b1, 4'h9, 1'b1, 4'h7, 8'h77},  // R5 read 9 / write 7
        {4'd5,  1'b1, 4'h7, 1'b0, 4'h0, 8'h00},  // R5 write took effect
        {4'd3,  1'b0, 4'h0, 1'b0, 4'h0, 8'h00},  // R3 hold
        {4'd2,  1'b1, 4'h9, 1'b1, 4'h0, 8'h00},  // R2 read while writing addr 0
        {4'd2,  1'b1, 4'h0, 1'b1, 4'hF, 8'h99},  // R2 read addr 0
        {4'd6,  1'b1, 4'hF, 1'b1, 4'hF, 8'h66},  // R6 collision at top address
        {4'd6,  1'b1, 4'hF, 1'b0, 4'h0, 8'h00},  // R6 top address new word
        {4'd3,  1'b0, 4'h0, 1'b0, 4'h0, 8'h00}   // R3 hold
    };

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic re, input logic [AW-1:0] ra,
                         input logic we, input logic [AW-1:0] wa, input logic [DW-1:0] wd);
        rd_en = re; rd_addr = ra; wr_en = we; wr_addr = wa; wr_data = wd;
        if (re) ref_rd = ref_mem[ra];   // read before write
        if (we) ref_mem[wa] = wd;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 check("R1 during reset", rd_data, '0);
        @(posedge clk); #1 rst_n = 1'b1;
        #2 check("R1 after release", rd_data, '0);

        for (int i = 0; i < NV; i++) begin
            @(posedge clk); #1;
            drive(VEC[i][17], VEC[i][16:13], VEC[i][12], VEC[i][11:8], VEC[i][7:0]);
            #2 check($sformatf("R%0d vec%0d", VEC[i][21:18], i), rd_data, ref_rd);
        end

        // R8 / R2: output changes only after the mid-cycle edge
        @(posedge clk); #1 drive(1'b0, 4'h0, 1'b1, 4'h5, 8'hC3);
        @(posedge clk); #1 drive(1'b1, 4'h5, 1'b0, 4'h0, 8'h00);
        #0.5 check("R8 before read phase", rd_data, 8'h66);
        #1.5 check("R2 after read phase", rd_data, 8'hC3);

        // R1: mid-run reset clears output, contents retained
        @(posedge clk); #1 drive(1'b0, 4'h0, 1'b0, 4'h0, 8'h00); rst_n = 1'b0;
        #2 check("R1 mid-run reset", rd_data, '0);
        @(posedge clk); @(posedge clk); #1 rst_n = 1'b1;
        #2 check("R1 idle after reset", rd_data, '0);

        // R6 / R9: collision right after reset proves phase realigned
        @(posedge clk); #1 drive(1'b1, 4'h5, 1'b1, 4'h5, 8'h0F);
        #2 check("R6 collision after reset", rd_data, 8'hC3);
        @(posedge clk); #1 drive(1'b1, 4'h5, 1'b0, 4'h0, 8'h00);
        #2 check("R9 write after reset", rd_data, 8'h0F);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule